// File: doc/BRIEF.md
# Divided clock-enable strobe generator

This block runs entirely in the fast system clock domain and produces two enable strobes that downstream logic uses in place of slower derived clocks. The auxiliary strobe always follows a slow, asynchronous low-frequency clock. The secondary strobe follows either that same slow clock or the fast oscillator that drives the system clock itself, chosen by a select bit. Each strobe has its own divider that passes one source event in 1, 2, 4 or 8.

The slow clock is brought into the system domain through a synchronizer chain, and its rising edges are found by comparing the synchronized level with its value one cycle earlier. Each divider counts source events and emits a strobe on the cycle after the event that wraps it. Strobes come straight from flops clocked on the rising edge, so they are steady when consumers sample them on the falling edge. A new divide setting is taken up only when the divider wraps, so a period that is already under way is never cut short or stretched by an extra pulse.

Top module: `clk_strobe_gen`

## Requirements
- R1: The auxiliary strobe pulses once per N rising edges of `lf_clk`, where the 2-bit `aux_div` field selects N: code 0 gives 1, code 1 gives 2, code 2 gives 4, code 3 gives 8.
- R2: The auxiliary strobe depends only on `lf_clk` and `aux_div`; the value of `sub_src_sel` has no effect on it.
- R3: With `sub_src_sel` = 1 the secondary strobe counts system clock cycles: it pulses once every N cycles for the `sub_div` code (same encoding as R1), and with code 0 it stays high on every cycle.
- R4: With `sub_src_sel` = 0 the secondary strobe pulses once per N rising edges of `lf_clk`, N chosen by `sub_div` with the R1 encoding.
- R5: A strobe derived from `lf_clk` is high for exactly one system clock cycle per pulse.
- R6: With two synchronizer stages, a rising edge of `lf_clk` that settles between clock edges produces its strobe (divide by 1) after the third rising clock edge that follows it.
- R7: A change of a divide field takes effect only at the next wrap of that divider: the period in progress completes with the old ratio.
- R8: While `rst` is high (synchronous, active high) both strobes are low, and the synchronizer, edge detector and divider counters are cleared; divider counting restarts from zero after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock, also the fast oscillator source |
| rst | input | 1 | Synchronous active-high reset |
| lf_clk | input | 1 | Asynchronous slow clock |
| sub_src_sel | input | 1 | Secondary strobe source: 0 slow clock, 1 system clock |
| aux_div | input | 2 | Auxiliary divide code (0:1, 1:2, 2:4, 3:8) |
| sub_div | input | 2 | Secondary divide code (0:1, 1:2, 2:4, 3:8) |
| aux_stb | output | 1 | Auxiliary enable strobe |
| sub_stb | output | 1 | Secondary enable strobe |

## Verification
A divider counter that skips or repeats a value, or a ratio register loaded at the wrong moment, shows up as a wrong pulse count over a whole number of slow periods, and in the divider-change case within the first period after the switch. A faulty synchronizer or edge detector shifts the first strobe away from the third clock edge after a slow rise, or doubles a strobe's width, which is visible within four cycles of that rise. Leakage of the source select into the auxiliary path changes the auxiliary pulse count in the same window where the secondary source is switched.

// File: rtl/clk_strobe_gen.sv
module clk_strobe_gen #(
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lf_clk,
  input  logic             sub_src_sel,
  input  logic [SEL_W-1:0] aux_div,
  input  logic [SEL_W-1:0] sub_div,
  output logic             aux_stb,
  output logic             sub_stb
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  function automatic logic [CNT_W-1:0] lim_of(input logic [SEL_W-1:0] code);
    return CNT_W'((32'd1 << code) - 32'd1);
  endfunction

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lf_prev;
  logic                   lf_rise;
  logic                   aux_ev, sub_ev;
  logic                   aux_wrap, sub_wrap;
  logic [CNT_W-1:0]       aux_cnt, aux_lim;
  logic [CNT_W-1:0]       sub_cnt, sub_lim;

  assign lf_rise  = sync_q[SYNC_STAGES-1] & ~lf_prev;
  assign aux_ev   = lf_rise;
  assign sub_ev   = sub_src_sel ? 1'b1 : lf_rise;
  assign aux_wrap = aux_ev && (aux_cnt == aux_lim);
  assign sub_wrap = sub_ev && (sub_cnt == sub_lim);

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= lf_clk;
      end
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], lf_clk};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      lf_prev <= 1'b0;
      aux_cnt <= '0;
      sub_cnt <= '0;
      aux_lim <= lim_of(aux_div);
      sub_lim <= lim_of(sub_div);
      aux_stb <= 1'b0;
      sub_stb <= 1'b0;
    end else begin
      lf_prev <= sync_q[SYNC_STAGES-1];
      aux_stb <= aux_wrap;
      sub_stb <= sub_wrap;
      if (aux_ev) begin
        if (aux_wrap) begin
          aux_cnt <= '0;
          aux_lim <= lim_of(aux_div);
        end else begin
          aux_cnt <= aux_cnt + 1'b1;
        end
      end
      if (sub_ev) begin
        if (sub_wrap) begin
          sub_cnt <= '0;
          sub_lim <= lim_of(sub_div);
        end else begin
          sub_cnt <= sub_cnt + 1'b1;
        end
      end
    end
  end
endmodule

module clk_strobe_gen_chk #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             lf_clk,
  input logic             sub_src_sel,
  input logic             aux_stb,
  input logic             sub_stb,
  input logic [CNT_W-1:0] aux_cnt,
  input logic [CNT_W-1:0] aux_lim,
  input logic [CNT_W-1:0] sub_cnt,
  input logic [CNT_W-1:0] sub_lim
);
  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!aux_stb && !sub_stb));

  // R5
  aux_width_chk: assert property (@(posedge clk) disable iff (rst)
    aux_stb |=> !aux_stb);

  // R6
  aux_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (aux_stb && !$past(rst, SYNC_STAGES + 2)) |->
      ($past(lf_clk, SYNC_STAGES + 1) && !$past(lf_clk, SYNC_STAGES + 2)));

  // R1
  aux_bound_chk: assert property (@(posedge clk) disable iff (rst)
    aux_cnt <= aux_lim);

  // R7
  sub_bound_chk: assert property (@(posedge clk) disable iff (rst)
    sub_cnt <= sub_lim);

  // R3
  sub_every_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (sub_src_sel && sub_lim == '0) |=> sub_stb);
endmodule

bind clk_strobe_gen clk_strobe_gen_chk #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .lf_clk(lf_clk), .sub_src_sel(sub_src_sel),
  .aux_stb(aux_stb), .sub_stb(sub_stb),
  .aux_cnt(aux_cnt), .aux_lim(aux_lim), .sub_cnt(sub_cnt), .sub_lim(sub_lim)
);

// File: tb/clk_strobe_gen_tb_top.sv
module clk_strobe_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lf_clk = 1'b0;
  logic       sub_src_sel = 1'b0;
  logic [1:0] aux_div = 2'd0;
  logic [1:0] sub_div = 2'd0;
  logic       aux_stb, sub_stb;

  int total = 0;
  int bad = 0;
  int aux_n = 0;
  int sub_n = 0;
  bit done = 0;

  localparam int LF_HALF = 15;
  localparam int LF_PERIODS = 24;

  always #5 clk = ~clk;

  clk_strobe_gen dut_i (
    .clk(clk), .rst(rst), .lf_clk(lf_clk), .sub_src_sel(sub_src_sel),
    .aux_div(aux_div), .sub_div(sub_div), .aux_stb(aux_stb), .sub_stb(sub_stb)
  );

  always @(negedge clk) begin
    if (aux_stb) aux_n <= aux_n + 1;
    if (sub_stb) sub_n <= sub_n + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    aux_n = 0;
    sub_n = 0;
  endtask

  task automatic lf_periods(input int n);
    for (int i = 0; i < n; i++) begin
      lf_clk = 1'b1;
      repeat (LF_HALF) @(negedge clk);
      lf_clk = 1'b0;
      repeat (LF_HALF) @(negedge clk);
    end
  endtask

  initial begin
    int a_snap, s_snap;
    // R8: strobes stay low while reset is held, with both sources active
    sub_src_sel = 1'b1;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    #1 aux_n = 0; sub_n = 0;
    for (int i = 0; i < 6; i++) begin
      lf_clk = ~lf_clk;
      repeat (2) @(negedge clk);
    end
    #1;
    check(aux_n == 0 && sub_n == 0, "R8", aux_n + sub_n, 0);
    lf_clk = 1'b0;

    // R1 / R4: both strobes from the slow clock, every divide code
    for (int d = 0; d < 4; d++) begin
      sub_src_sel = 1'b0;
      aux_div = 2'(d);
      sub_div = 2'(3 - d);
      do_reset();
      lf_periods(LF_PERIODS);
      #1;
      check(aux_n == (LF_PERIODS >> d), "R1", aux_n, LF_PERIODS >> d);
      check(sub_n == (LF_PERIODS >> (3 - d)), "R4", sub_n, LF_PERIODS >> (3 - d));
    end

    // R3 / R2: secondary from system clock, auxiliary unaffected
    for (int d = 0; d < 4; d++) begin
      sub_src_sel = 1'b1;
      aux_div = 2'(3 - d);
      sub_div = 2'(d);
      do_reset();
      lf_periods(LF_PERIODS);
      #1;
      s_snap = sub_n;
      a_snap = aux_n;
      check(s_snap == (2 * LF_HALF * LF_PERIODS) >> d, "R3", s_snap, (2 * LF_HALF * LF_PERIODS) >> d);
      check(a_snap == (LF_PERIODS >> (3 - d)), "R2", a_snap, LF_PERIODS >> (3 - d));
    end

    // R2: flipping the source select mid-run leaves auxiliary count intact
    aux_div = 2'd1;
    sub_div = 2'd2;
    sub_src_sel = 1'b0;
    do_reset();
    for (int i = 0; i < 8; i++) begin
      sub_src_sel = ~sub_src_sel;
      lf_periods(1);
    end
    #1;
    check(aux_n == 4, "R2", aux_n, 4);

    // R6 / R5: latency of three edges and single-cycle width
    aux_div = 2'd0;
    sub_src_sel = 1'b0;
    sub_div = 2'd0;
    do_reset();
    repeat (4) @(negedge clk);
    lf_clk = 1'b1;
    @(negedge clk); #1;
    check(aux_stb == 1'b0, "R6", aux_stb, 0);
    @(negedge clk); #1;
    check(aux_stb == 1'b0, "R6", aux_stb, 0);
    @(negedge clk); #1;
    check(aux_stb == 1'b1, "R6", aux_stb, 1);
    check(sub_stb == 1'b1, "R4", sub_stb, 1);
    @(negedge clk); #1;
    check(aux_stb == 1'b0, "R5", aux_stb, 0);
    check(sub_stb == 1'b0, "R5", sub_stb, 0);
    repeat (10) @(negedge clk);
    lf_clk = 1'b0;
    repeat (LF_HALF) @(negedge clk);

    // R7: switch from /8 to /2 after three edges; old period completes
    aux_div = 2'd3;
    do_reset();
    lf_periods(3);
    aux_div = 2'd1;
    lf_periods(4);
    #1;
    check(aux_n == 0, "R7", aux_n, 0);
    lf_periods(1);
    #1;
    check(aux_n == 1, "R7", aux_n, 1);
    lf_periods(2);
    #1;
    check(aux_n == 2, "R7", aux_n, 2);

    // R8: counter restarts from zero after reset mid-period
    aux_div = 2'd2;
    do_reset();
    lf_periods(3);
    do_reset();
    lf_periods(3);
    #1;
    check(aux_n == 0, "R8", aux_n, 0);
    lf_periods(1);
    #1;
    check(aux_n == 1, "R8", aux_n, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule